// File: doc/BRIEF.md
# Preamble-Synchronised Sector Byte Framer

This block sits in the read path of a removable-cartridge disk, after MFM bit recovery. It receives one decoded data bit per `bit_valid_i` strobe and turns the serial stream into aligned words. Each region of a sector begins with a preamble. The preamble is a run of zero bits that ends in a single one bit. The block locks word alignment on that one bit, then packs the bits that follow into `WORD_W`-bit words. Each word comes out with a single-cycle strobe and a flag that tells header from data.

The header and the data area are written at different times, so their bit phases are unrelated. For this reason the block counts the header bits. It drops sync as soon as the last header CRC bit has been framed, and it then skips a fixed gap of bit times. After the gap it hunts for the data preamble from scratch, which gives the data area its own lock. When the data length has been framed, the block waits for the next sector pulse.

While the sector pulse is high, all incoming bits are discarded and the framing state returns to the header hunt. Servo information is therefore never decoded.

Top module: `sector_framer`

## Requirements
- R1: After reset the block hunts for the header preamble: `word_valid_o`, `in_sync_o` and `region_o` are all 0.
- R2: Lock needs at least `MIN_ZEROS` (default 16) consecutive zero bits followed by a one bit. That one bit is consumed as a marker and is not placed in any word. A one bit that arrives before the zero run is long enough restarts the count and does not lock. A preamble longer than the minimum also locks.
- R3: Once locked, every `WORD_W` (default 8) accepted bits form one word. The earliest received bit is placed at `word_o[WORD_W-1]`. `word_valid_o` is a pulse of one clock that appears in the cycle after the clock edge that sampled the word's last bit.
- R4: When `HDR_BITS` (default 48) header bits have been framed, `in_sync_o` falls in the same cycle that the last header word is presented.
- R5: The `GAP_BITS` (32) valid bits that follow the header are ignored, even when they contain a valid preamble pattern.
- R6: The data area is framed by a new preamble hunt under the same rule as R2. Header words carry `region_o`=0 and data words carry `region_o`=1.
- R7: When `DATA_BITS` (default 64) data bits have been framed, no further words appear and `in_sync_o` stays 0 until a sector pulse, whatever bits arrive.
- R8: While `sector_pulse_i` is 1, bits are ignored and framing returns to the header hunt. This holds at any point in a sector, including in the middle of a header.
- R9: `in_sync_o` is 1 exactly while words are being framed in the header or data area, and every word is emitted while in sync.
- R10: Clock cycles with `bit_valid_i`=0 do not advance any framing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Decoded data bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for one cycle |
| sector_pulse_i | input | 1 | Sector pulse; gates off bits and clears framing |
| word_o | output | WORD_W | Framed word, earliest bit in the MSB |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |
| region_o | output | 1 | 0 = header region, 1 = data region |
| in_sync_o | output | 1 | Word alignment is locked |

## Verification
Sectors are driven in several forms:
- An exact 16-zero preamble, and a longer 40-zero preamble. These separate a minimum-length lock from a saturating run count.
- A false one bit after only 10 zeros. This shows whether a short run restarts the hunt or locks too early; an early lock would misalign every header word.
- A gap that holds its own zero run and one bit. This distinguishes a block that ignores all 32 gap bits from one that hunts during the gap.
- Bits after the data area, and bits during a sector pulse that cuts a header short. These must produce no words.
- Bits spaced by irregular idle cycles. These confirm that only strobed bits advance the framing.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_HUNT_HDR  = 3'd0,
    ST_HDR       = 3'd1,
    ST_GAP       = 3'd2,
    ST_HUNT_DATA = 3'd3,
    ST_DATA      = 3'd4,
    ST_IDLE      = 3'd5
  } sfr_state_e;

  function automatic int unsigned sfr_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sfr_zero_hunt.sv
module sfr_zero_hunt #(
  parameter int unsigned MIN_ZEROS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic bit_i,
  output logic lock_o
);
  localparam int unsigned ZW = $clog2(MIN_ZEROS + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(MIN_ZEROS);

  logic [ZW-1:0] zcnt_q;
  logic          run_ok;

  assign run_ok = (zcnt_q == ZMAX);
  assign lock_o = step_i && bit_i && run_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zcnt_q <= '0;
    end else if (clear_i) begin
      zcnt_q <= '0;
    end else if (step_i) begin
      if (bit_i)        zcnt_q <= '0;          // early one restarts the hunt
      else if (!run_ok) zcnt_q <= zcnt_q + 1'b1; // saturate at the minimum
    end
  end
endmodule

// File: rtl/sfr_word_pack.sv
module sfr_word_pack #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned PW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] shreg_nx;
  logic [PW-1:0]     pos_q;
  logic              done;

  generate
    if (WORD_W > 1) begin : g_wide
      assign shreg_nx = {shreg_q[WORD_W-2:0], bit_i};
    end else begin : g_single
      assign shreg_nx = bit_i;
    end
  endgenerate

  assign done = shift_i && (pos_q == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q      <= '0;
      pos_q        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else if (clear_i) begin
      shreg_q      <= '0;
      pos_q        <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= done;
      if (shift_i) begin
        shreg_q <= shreg_nx;
        pos_q   <= done ? '0 : pos_q + 1'b1;
      end
      if (done) word_o <= shreg_nx;
    end
  end
endmodule

// File: rtl/sfr_span_count.sv
module sfr_span_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = step_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || hit_o) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sector_framer.sv
module sector_framer #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned HDR_BITS  = 48,
  parameter int unsigned DATA_BITS = 64,
  parameter int unsigned GAP_BITS  = 32,
  parameter int unsigned MIN_ZEROS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              sector_pulse_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              region_o,
  output logic              in_sync_o
);
  import sfr_pkg::*;

  localparam int unsigned SPAN_MAX = sfr_max3(HDR_BITS, DATA_BITS, GAP_BITS);
  localparam int unsigned CNT_W    = $clog2(SPAN_MAX + 1);

  generate
    if ((HDR_BITS % WORD_W) != 0 || (DATA_BITS % WORD_W) != 0) begin : g_bad_len
      $error("region lengths must be whole words");
    end
  endgenerate

  sfr_state_e       state_q, state_d;
  logic             bit_ev;
  logic             hunting, framing, gapping;
  logic             lock, span_hit;
  logic [CNT_W-1:0] span_limit;

  assign bit_ev  = bit_valid_i && !sector_pulse_i;
  assign hunting = (state_q == ST_HUNT_HDR) || (state_q == ST_HUNT_DATA);
  assign framing = (state_q == ST_HDR) || (state_q == ST_DATA);
  assign gapping = (state_q == ST_GAP);

  always_comb begin
    unique case (state_q)
      ST_HDR:  span_limit = CNT_W'(HDR_BITS);
      ST_DATA: span_limit = CNT_W'(DATA_BITS);
      default: span_limit = CNT_W'(GAP_BITS);
    endcase
  end

  sfr_zero_hunt #(.MIN_ZEROS(MIN_ZEROS)) i_hunt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(sector_pulse_i || !hunting),
    .step_i (bit_ev && hunting),
    .bit_i  (bit_i),
    .lock_o (lock)
  );

  sfr_word_pack #(.WORD_W(WORD_W)) i_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (sector_pulse_i || lock),
    .shift_i     (bit_ev && framing),
    .bit_i       (bit_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o)
  );

  sfr_span_count #(.CNT_W(CNT_W)) i_span (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(sector_pulse_i || lock),
    .step_i (bit_ev && (framing || gapping)),
    .limit_i(span_limit),
    .hit_o  (span_hit)
  );

  always_comb begin
    state_d = state_q;
    if (sector_pulse_i) begin
      state_d = ST_HUNT_HDR;
    end else begin
      unique case (state_q)
        ST_HUNT_HDR:  if (lock)     state_d = ST_HDR;
        ST_HDR:       if (span_hit) state_d = ST_GAP;
        ST_GAP:       if (span_hit) state_d = ST_HUNT_DATA;
        ST_HUNT_DATA: if (lock)     state_d = ST_DATA;
        ST_DATA:      if (span_hit) state_d = ST_IDLE;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT_HDR;
    else         state_q <= state_d;
  end

  assign in_sync_o = framing;
  assign region_o  = (state_q == ST_HUNT_DATA) || (state_q == ST_DATA) || (state_q == ST_IDLE);
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_i,
  input logic bit_valid_i,
  input logic sector_pulse_i,
  input logic word_valid_o,
  input logic region_o,
  input logic in_sync_o
);
  // R2: lock only follows a sampled one bit
  a_r2_lock_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> $past(bit_i && bit_valid_i && !sector_pulse_i));

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  a_r6_region_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $stable(region_o));

  a_r8_pulse_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_pulse_i |=> (!in_sync_o && !word_valid_o && !region_o));

  a_r9_word_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(in_sync_o));

  a_r10_no_strobe_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !sector_pulse_i) |=> ($stable(in_sync_o) && !word_valid_o));
endmodule

bind sector_framer sfr_checker i_sfr_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bit_i         (bit_i),
  .bit_valid_i   (bit_valid_i),
  .sector_pulse_i(sector_pulse_i),
  .word_valid_o  (word_valid_o),
  .region_o      (region_o),
  .in_sync_o     (in_sync_o)
);

// File: tb/test_sector_framer.sv
module test_sector_framer;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bit_i = 1'b0;
  logic              bit_valid_i = 1'b0;
  logic              sector_pulse_i = 1'b0;
  logic [WORD_W-1:0] word_o;
  logic              word_valid_o;
  logic              region_o;
  logic              in_sync_o;

  int errs = 0;
  int checks = 0;
  int spacing = 0;
  logic [WORD_W:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sector_framer i_sector_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .sector_pulse_i(sector_pulse_i), .word_o(word_o), .word_valid_o(word_valid_o),
    .region_o(region_o), .in_sync_o(in_sync_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor (R3, R6, R7)
  always @(negedge clk_i) begin
    if (rst_ni && word_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected word", {region_o, word_o}, 0);
      end else begin
        logic [WORD_W:0] e;
        e = exp_q.pop_front();
        chk({region_o, word_o} == e, "R3/R6 word and region", {region_o, word_o}, e);
      end
    end
  end

  // R10: irregular idle cycles between bits
  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b;
    bit_valid_i = 1'b1;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    spacing = (spacing + 1) % 4;
    repeat (spacing == 3 ? 2 : 0) @(negedge clk_i);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w, input logic reg_flag, input logic expect_it);
    if (expect_it) exp_q.push_back({reg_flag, w});
    for (int i = WORD_W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse(input logic with_bits);
    @(negedge clk_i);
    sector_pulse_i = 1'b1;
    if (with_bits) begin
      send_zeros(20);
      send_bit(1'b1);
      send_word(8'hA5, 1'b0, 1'b0);
    end else begin
      repeat (3) @(negedge clk_i);
    end
    sector_pulse_i = 1'b0;
    chk(!in_sync_o && !region_o && !word_valid_o, "R8 pulse clears", {in_sync_o, region_o}, 0);
  endtask

  task automatic header(input int base);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) chk(in_sync_o, "R9 in sync during header", in_sync_o, 1);
      send_word(WORD_W'(base + i * 17), 1'b0, 1'b1);
    end
    chk(!in_sync_o, "R4 sync dropped after header", in_sync_o, 0);
    chk(!region_o, "R4 region header in gap", region_o, 0);
  endtask

  task automatic gap_with_decoy();
    send_zeros(20);
    send_bit(1'b1);
    chk(!in_sync_o, "R5 decoy preamble ignored in gap", in_sync_o, 0);
    send_zeros(10);
    send_bit(1'b1);
    chk(!in_sync_o && !region_o == 1'b0, "R5 gap over, hunting data", {in_sync_o, region_o}, 1);
  endtask

  task automatic data_area(input int base);
    for (int i = 0; i < 8; i++) send_word(WORD_W'(base ^ (i * 29)), 1'b1, 1'b1);
    chk(!in_sync_o && region_o, "R7 idle after data", {in_sync_o, region_o}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!word_valid_o && !in_sync_o && !region_o, "R1 reset state",
        {word_valid_o, in_sync_o, region_o}, 0);
    rst_ni = 1'b1;

    // sector 1: exact minimum preamble
    pulse(1'b0);
    send_zeros(16);
    send_bit(1'b1);
    chk(in_sync_o, "R2 locked on minimum preamble", in_sync_o, 1);
    header(8'h10);
    gap_with_decoy();
    send_zeros(16);
    send_bit(1'b1);
    chk(in_sync_o && region_o, "R6 data lock", {in_sync_o, region_o}, 3);
    data_area(8'h3C);
    // R7: bits after data produce nothing
    send_zeros(20);
    send_bit(1'b1);
    send_word(8'hFF, 1'b1, 1'b0);
    chk(!in_sync_o, "R7 stays out of sync", in_sync_o, 0);

    // sector 2: early one restarts, long data preamble
    pulse(1'b0);
    send_zeros(10);
    send_bit(1'b1);
    chk(!in_sync_o, "R2 short run does not lock", in_sync_o, 0);
    send_zeros(16);
    send_bit(1'b1);
    header(8'h81);
    gap_with_decoy();
    send_zeros(40);
    send_bit(1'b1);
    chk(in_sync_o, "R2 long preamble locks", in_sync_o, 1);
    data_area(8'hC3);

    // sector 3: pulse mid-header with bits during the pulse
    pulse(1'b0);
    send_zeros(16);
    send_bit(1'b1);
    send_word(8'h5A, 1'b0, 1'b1);
    send_word(8'h00, 1'b0, 1'b1);
    pulse(1'b1);
    send_zeros(17);
    send_bit(1'b1);
    header(8'h07);
    gap_with_decoy();
    send_zeros(16);
    send_bit(1'b1);
    data_area(8'h99);

    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 all expected words seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule